// File: doc/BRIEF.md
# Programmable-Frame Serial Receiver with Polling Path

This block receives asynchronous serial characters on a single input line. The line is first synchronised to the block clock. The receiver watches for the falling edge that opens a start bit and confirms it half a bit period later. It then samples every later bit at its centre, with one bit period lasting DIV+1 clock cycles. At run time, software chooses a data length of 5 to 8 bits, whether an even parity bit follows, and whether the frame ends with one or two stop bits.

Each finished character takes one of two paths. In streaming mode it enters a small FIFO that drains through a valid/ready output toward a DMA channel. In polling mode it lands in a data register that software reads, and a valid flag shows that a character is waiting. Parity and overflow faults are kept in read-to-clear flags. Two interrupt outputs, each with its own enable, report received data and errors. A status bit shows that a frame is in progress.

The register port uses a 3-bit word address. Reads return data in the same cycle, combinationally from the address. Any side effect of a read or write takes effect at the next clock edge.

Top module: `serial_rx_poll`

## Requirements
- R1: Word address 0 is the setup register. Bits 31:16 hold DIV, bit 9 enables the receiver, bit 4 selects polling mode, bit 3 selects two stop bits, bits 2:1 hold the length code and bit 0 enables parity. Bit 5 is a flush command that reads back as 0. All other bits read 0. Word address 1 is the error register, 2 the interrupt enable register, 3 the status register, 4 the valid register and 5 the data register.
- R2: One bit period is DIV+1 cycles. A low pulse on the line that ends before the half-period re-check does not start a frame and delivers nothing.
- R3: Length code 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits arrive least significant first. Unused upper bits of the delivered byte are zero.
- R4: With parity enabled, an even parity bit follows the data bits. A mismatch sets error bit 1, and the byte is still delivered.
- R5: The stop bit is checked, and with two stop bits selected the second one is checked too. If a stop bit is sampled low, the frame is discarded.
- R6: In streaming mode, bytes enter a FIFO of FIFO_DEPTH entries and leave in order on stm_valid/stm_data, one per cycle in which stm_ready is high. A byte that completes while the FIFO is full is dropped and sets error bit 0 (overflow).
- R7: In polling mode, a byte is written to the data register (bits 7:0) and sets the valid flag (valid register bit 0). Reading the data register clears the valid flag. A byte that completes while the flag is still set replaces the old byte and sets error bit 0.
- R8: Reading the error register clears both error flags. If a new error event occurs in the same cycle as the read, that event takes priority and the flag stays set.
- R9: In the interrupt enable register, bit 1 enables irq_err and bit 0 enables irq_rx. irq_err is high while it is enabled and an error flag is set. irq_rx is high while it is enabled and data is waiting: the valid flag in polling mode, or a non-empty FIFO in streaming mode.
- R10: Status bit 0 is high while a frame is in progress. With the receiver disabled, no frame starts and the status bit stays low.
- R11: Writing the setup register with bit 5 set empties the FIFO in the following cycle.
- R12: After reset, every register reads 0, and stm_valid, irq_rx and irq_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| stm_valid | output | 1 | Streaming byte available |
| stm_data | output | 8 | Streaming byte at the FIFO head |
| stm_ready | input | 1 | Consumer takes the head byte |
| irq_rx | output | 1 | Receive data interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The hardest situations to reach from the ports are a frame that is discarded mid-stream and a start pulse that never becomes a frame. The bench reaches them through a serial driver that can invert the parity bit, pull either stop bit low, or drop the line for only two cycles. After each of these it reads the valid flag and the status bit to confirm nothing was delivered. Overflow in both modes is produced by withholding the consumer: stm_ready is held low, or the data register is not read, while more characters arrive than can be held. The busy status is caught by issuing a register read while the line is held low in the middle of a frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef struct packed {
        logic [15:0] div;
        logic        rx_en;
        logic        poll;
        logic        two_stop;
        logic [1:0]  len;
        logic        par_en;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_bad;
    } rx_word_t;

    localparam logic [2:0] A_SETUP = 3'd0;
    localparam logic [2:0] A_ERR   = 3'd1;
    localparam logic [2:0] A_IRQ   = 3'd2;
    localparam logic [2:0] A_STAT  = 3'd3;
    localparam logic [2:0] A_VALID = 3'd4;
    localparam logic [2:0] A_DATA  = 3'd5;

    localparam int unsigned FLUSH_BIT = 5;

    // index of the final data bit for a length code (code 0 -> 5 bits)
    function automatic logic [2:0] last_idx(input logic [1:0] len);
        return {1'b0, len} + 3'd4;
    endfunction

    function automatic rx_cfg_t unpack_setup(input logic [31:0] w);
        rx_cfg_t c;
        c.div      = w[31:16];
        c.rx_en    = w[9];
        c.poll     = w[4];
        c.two_stop = w[3];
        c.len      = w[2:1];
        c.par_en   = w[0];
        return c;
    endfunction

    function automatic logic [31:0] pack_setup(input rx_cfg_t c);
        return {c.div, 6'd0, c.rx_en, 3'd0, 1'b0, c.poll, c.two_stop, c.len, c.par_en};
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b1;
                end else begin
                    chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import serial_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line,
    input  rx_cfg_t  cfg,
    output logic     done,
    output rx_word_t word,
    output logic     busy
);
    rx_state_t   state;
    logic [15:0] cnt;
    logic [2:0]  idx;
    logic [7:0]  shreg;
    logic        acc;
    logic        par_bad;
    logic        stop_left;
    logic        prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            acc       <= 1'b0;
            par_bad   <= 1'b0;
            stop_left <= 1'b0;
            done      <= 1'b0;
            prev      <= 1'b1;
        end else begin
            done <= 1'b0;
            prev <= line;
            if (!cfg.rx_en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (prev && !line) begin
                            state <= ST_START;
                            cnt   <= cfg.div >> 1;
                        end
                    end
                    ST_START: begin
                        if (cnt != 16'd0) begin
                            cnt <= cnt - 16'd1;
                        end else if (!line) begin
                            state   <= ST_DATA;
                            cnt     <= cfg.div;
                            idx     <= '0;
                            shreg   <= '0;
                            acc     <= 1'b0;
                            par_bad <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        if (cnt != 16'd0) begin
                            cnt <= cnt - 16'd1;
                        end else begin
                            shreg[idx] <= line;
                            acc        <= acc ^ line;
                            cnt        <= cfg.div;
                            if (idx == last_idx(cfg.len)) begin
                                state     <= cfg.par_en ? ST_PAR : ST_STOP;
                                stop_left <= cfg.two_stop;
                            end else begin
                                idx <= idx + 3'd1;
                            end
                        end
                    end
                    ST_PAR: begin
                        if (cnt != 16'd0) begin
                            cnt <= cnt - 16'd1;
                        end else begin
                            par_bad <= line ^ acc;
                            cnt     <= cfg.div;
                            state   <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        if (cnt != 16'd0) begin
                            cnt <= cnt - 16'd1;
                        end else if (!line) begin
                            state <= ST_IDLE;
                        end else if (stop_left) begin
                            stop_left <= 1'b0;
                            cnt       <= cfg.div;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign word = '{data: shreg, par_bad: par_bad};
    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == FULLC);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= push_data;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/serial_rx_poll.sv
module serial_rx_poll
    import serial_rx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_line,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        stm_valid,
    output logic [7:0]  stm_data,
    input  logic        stm_ready,
    output logic        irq_rx,
    output logic        irq_err
);
    rx_cfg_t  cfg_q;
    logic [1:0] irqen_q;
    logic     par_flag, ovf_flag;
    logic     pvalid_q;
    logic [7:0] pdata_q;
    logic     line_s;
    logic     frm_done, frm_busy;
    rx_word_t frm_word;
    logic     fifo_full, fifo_empty;
    logic     flush_req, rd_err, rd_data, overflow_ev;

    // write-data bits with no function in this block
    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[15:10], reg_wdata[8:6]};

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(rx_line), .q(line_s)
    );

    srx_framer u_frm (
        .clk(clk), .rst(rst), .line(line_s), .cfg(cfg_q),
        .done(frm_done), .word(frm_word), .busy(frm_busy)
    );

    assign flush_req = reg_wr && (reg_addr == A_SETUP) && reg_wdata[FLUSH_BIT];
    assign rd_err    = reg_rd && (reg_addr == A_ERR);
    assign rd_data   = reg_rd && (reg_addr == A_DATA);
    assign overflow_ev = frm_done && (cfg_q.poll ? (pvalid_q && !rd_data) : fifo_full);

    srx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(flush_req),
        .push(frm_done && !cfg_q.poll), .push_data(frm_word.data),
        .pop(stm_ready), .head(stm_data),
        .full(fifo_full), .empty(fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            irqen_q  <= '0;
            par_flag <= 1'b0;
            ovf_flag <= 1'b0;
            pvalid_q <= 1'b0;
            pdata_q  <= '0;
        end else begin
            if (reg_wr && reg_addr == A_SETUP) cfg_q <= unpack_setup(reg_wdata);
            if (reg_wr && reg_addr == A_IRQ)   irqen_q <= reg_wdata[1:0];

            if (frm_done && frm_word.par_bad) par_flag <= 1'b1;
            else if (rd_err)                  par_flag <= 1'b0;

            if (overflow_ev)  ovf_flag <= 1'b1;
            else if (rd_err)  ovf_flag <= 1'b0;

            if (frm_done && cfg_q.poll) begin
                pvalid_q <= 1'b1;
                pdata_q  <= frm_word.data;
            end else if (rd_data) begin
                pvalid_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_SETUP: reg_rdata = pack_setup(cfg_q);
            A_ERR:   reg_rdata = {30'd0, par_flag, ovf_flag};
            A_IRQ:   reg_rdata = {30'd0, irqen_q};
            A_STAT:  reg_rdata = {31'd0, frm_busy};
            A_VALID: reg_rdata = {31'd0, pvalid_q};
            A_DATA:  reg_rdata = {24'd0, pdata_q};
            default: reg_rdata = '0;
        endcase
    end

    assign stm_valid = !fifo_empty;
    assign irq_rx    = irqen_q[0] && (cfg_q.poll ? pvalid_q : !fifo_empty);
    assign irq_err   = irqen_q[1] && (par_flag || ovf_flag);
endmodule

module srx_chk
    import serial_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       reg_rd,
    input logic [2:0] reg_addr,
    input logic       frm_done,
    input logic       par_bad,
    input logic       poll,
    input logic       rx_en,
    input logic       busy,
    input logic       par_flag,
    input logic       ovf_flag,
    input logic       pvalid,
    input logic       flush_req,
    input logic       stm_valid,
    input logic       stm_ready,
    input logic [7:0] stm_data
);
    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_ERR && !frm_done) |=> (!par_flag && !ovf_flag));

    // R4
    par_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_done && par_bad) |=> par_flag);

    // R7
    valid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_DATA && !frm_done) |=> !pvalid);

    // R7
    poll_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_done && poll) |=> pvalid);

    // R10
    idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !busy);

    // R6
    stm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stm_valid && !stm_ready && !flush_req) |=> (stm_valid && $stable(stm_data)));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !stm_valid);
endmodule

bind serial_rx_poll srx_chk u_chk (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .frm_done(frm_done), .par_bad(frm_word.par_bad), .poll(cfg_q.poll),
    .rx_en(cfg_q.rx_en), .busy(frm_busy), .par_flag(par_flag),
    .ovf_flag(ovf_flag), .pvalid(pvalid_q), .flush_req(flush_req),
    .stm_valid(stm_valid), .stm_ready(stm_ready), .stm_data(stm_data)
);

// File: tb/sim_serial_rx_poll.sv
module sim_serial_rx_poll;
    localparam int DIV   = 7;
    localparam int P     = DIV + 1;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        stm_valid, stm_ready = 1'b0;
    logic [7:0]  stm_data;
    logic        irq_rx, irq_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    serial_rx_poll #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .rx_line(rx_line),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stm_valid(stm_valid), .stm_data(stm_data), .stm_ready(stm_ready),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] su(input int len, input bit stop2, input bit par,
                                       input bit poll, input bit en);
        return (32'(DIV) << 16) | (32'(en) << 9) | (32'(poll) << 4) |
               (32'(stop2) << 3) | (32'(len) << 1) | 32'(par);
    endfunction

    task automatic bitout(input logic b);
        rx_line = b;
        repeat (P) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int len, input bit par, input bit stop2,
                        input bit bad_par, input bit bad_s1, input bit bad_s2);
        logic p;
        p = 1'b0;
        @(negedge clk);
        bitout(1'b0);
        for (int i = 0; i < len + 5; i++) begin
            bitout(d[i]);
            p ^= d[i];
        end
        if (par) bitout(p ^ bad_par);
        bitout(!bad_s1);
        if (stop2) bitout(!bad_s2);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    logic [31:0] v;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R12 reset reg", v, 32'd0);
        end
        chk("R12 stm_valid", {31'd0, stm_valid}, 32'd0);
        chk("R12 irqs", {30'd0, irq_rx, irq_err}, 32'd0);

        // R1 setup layout, flush bit reads 0
        wr(3'd0, 32'h1234_023F);
        rd(3'd0, v);
        chk("R1 setup readback", v, 32'h1234_021F);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v);
        chk("R1 irq enable readback", v, 32'd3);
        wr(3'd2, 32'd0);

        // R3 R4 R5 R7 sweep over all formats in polling mode
        for (int len = 0; len < 4; len++)
            for (int s2 = 0; s2 < 2; s2++)
                for (int pe = 0; pe < 2; pe++)
                    for (int k = 0; k < 5; k++) begin
                        logic [7:0] d;
                        logic [31:0] mask;
                        d = 8'(8'hA5 * (k + 1) + 8'(len * 17) + 8'(s2 * 3) + 8'(pe));
                        if (k == 4) d = 8'hFF;
                        mask = (32'd1 << (len + 5)) - 1;
                        wr(3'd0, su(len, s2[0], pe[0], 1'b1, 1'b1));
                        send(d, len, pe[0], s2[0], 1'b0, 1'b0, 1'b0);
                        rd(3'd4, v);
                        chk("R7 valid set", v, 32'd1);
                        rd(3'd5, v);
                        chk("R3 data length/zero-extend", v, {24'd0, d} & mask);
                        rd(3'd4, v);
                        chk("R7 valid cleared by data read", v, 32'd0);
                        rd(3'd1, v);
                        chk("R5 R4 no error", v, 32'd0);
                    end

        // R4 parity mismatch still delivered
        wr(3'd0, su(3, 1'b0, 1'b1, 1'b1, 1'b1));
        send(8'h96, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        rd(3'd5, v);
        chk("R4 byte delivered with bad parity", v, 32'h96);
        rd(3'd1, v);
        chk("R4 parity flag", v, 32'd2);
        rd(3'd1, v);
        chk("R8 error cleared by read", v, 32'd0);

        // R5 bad stop bits discard the frame
        send(8'h33, 3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(3'd4, v);
        chk("R5 bad single stop discarded", v, 32'd0);
        wr(3'd0, su(3, 1'b1, 1'b0, 1'b1, 1'b1));
        send(8'h44, 3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(3'd4, v);
        chk("R5 bad second stop discarded", v, 32'd0);

        // R7 overflow in polling mode, newest byte kept
        wr(3'd0, su(3, 1'b0, 1'b0, 1'b1, 1'b1));
        send(8'h11, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h22, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(3'd2, 32'd3);
        chk("R9 irq_err on overflow", {31'd0, irq_err}, 32'd1);
        chk("R9 irq_rx on valid", {31'd0, irq_rx}, 32'd1);
        wr(3'd2, 32'd1);
        chk("R9 irq_err masked", {31'd0, irq_err}, 32'd0);
        wr(3'd2, 32'd3);
        rd(3'd1, v);
        chk("R7 overflow flag", v, 32'd1);
        chk("R9 irq_err cleared", {31'd0, irq_err}, 32'd0);
        rd(3'd5, v);
        chk("R7 newest byte", v, 32'h22);
        chk("R9 irq_rx cleared", {31'd0, irq_rx}, 32'd0);

        // R2 short glitch does not start a frame
        @(negedge clk);
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * P) @(negedge clk);
        rd(3'd3, v);
        chk("R2 glitch not busy", v, 32'd0);
        rd(3'd4, v);
        chk("R2 glitch no delivery", v, 32'd0);

        // R10 busy mid-frame (byte 0x00, 8 bits)
        @(negedge clk);
        rx_line = 1'b0;
        repeat (P) @(negedge clk);
        rd(3'd3, v);
        chk("R10 busy during frame", v, 32'd1);
        repeat (8 * P - 2) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * P) @(negedge clk);
        rd(3'd4, v);
        chk("R2 zero byte valid", v, 32'd1);
        rd(3'd5, v);
        chk("R2 zero byte data", v, 32'd0);

        // R10 receiver disabled
        wr(3'd0, su(3, 1'b0, 1'b0, 1'b1, 1'b0));
        send(8'h5A, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(3'd4, v);
        chk("R10 disabled no delivery", v, 32'd0);
        rd(3'd3, v);
        chk("R10 disabled not busy", v, 32'd0);

        // R6 streaming order and overflow
        wr(3'd0, su(3, 1'b0, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < DEPTH + 1; i++)
            send(8'(8'h40 + i), 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 stm_valid", {31'd0, stm_valid}, 32'd1);
        chk("R9 irq_rx streaming", {31'd0, irq_rx}, 32'd1);
        rd(3'd1, v);
        chk("R6 fifo overflow flag", v, 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk("R6 stream order", {24'd0, stm_data}, 32'(8'h40 + i));
            stm_ready = 1'b1;
            @(negedge clk);
            stm_ready = 1'b0;
        end
        chk("R6 fifo drained", {31'd0, stm_valid}, 32'd0);

        // R11 flush
        send(8'h71, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h72, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 fifo filled", {31'd0, stm_valid}, 32'd1);
        wr(3'd0, su(3, 1'b0, 1'b0, 1'b0, 1'b1) | 32'h20);
        chk("R11 flush empties", {31'd0, stm_valid}, 32'd0);
        chk("R11 irq_rx after flush", {31'd0, irq_rx}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule